// File: doc/BRIEF.md
# Two-Wire Register Target with Block and Byte Access

This block is a two-wire serial (I2C) target that gives a host access to a small bank of eight-bit configuration registers. It answers at one fixed device address. A write frame first carries a command byte. A command of zero selects block mode: a byte count follows, and that many data bytes fill the registers upward from the first control index. Any other command value selects byte mode and names one register, with the command equal to the register index plus one.

Reads use a repeated START after the command. In block mode the target first returns the number of registers in the bank from the first control index upward, then the register contents from that index on. In byte mode it returns the named register. Each further byte follows for as long as the host acknowledges.

The bank holds three kinds of entries. Stored control registers drive the `ctrl_o` bus. Live entries return input levels such as straps or counter values at the moment they are read. Two constant entries identify the device. Indexes 0 to 3 are reserved. The bus lines are oversampled by the system clock, and the open-drain pad itself is outside the block: the block only requests a low drive on SDA.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the target leaves SDA released until the next START.
- R2: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP. A STOP releases SDA and ends the frame. A START in the middle of a frame restarts address reception.
- R3: Block write (command 0x00) takes a count N and then N data bytes, written to indexes 4, 5, ... in order. Bytes beyond N are not acknowledged and not written. With a count of 0, no data byte is accepted.
- R4: A read after a block command returns the count 12 first and then the registers from index 4 upward. The target releases SDA once the host answers a byte with no acknowledge.
- R5: Byte-data write: a command c (1..255) is followed by one data byte written to index c-1. Further bytes in the same frame are not acknowledged and not written.
- R6: Byte-data read: after command c, a read returns index c-1. Each host acknowledge moves on to the next index.
- R7: Indexes 0 to 3 are reserved. Writes to them change nothing, and reads return 0x00.
- R8: Index 14 always reads 0x77 and index 15 always reads 0x11. Writes to them are ignored.
- R9: Indexes 12 and 13 return `live_i[7:0]` and `live_i[15:8]` as they are when the byte is loaded for sending. Writes to them are ignored.
- R10: Indexes 4 to 11 are stored and appear on `ctrl_o`, with index 4 at bits 7:0 and each later index eight bits higher. They reset to 0x00 and change only on an acknowledged data byte.
- R11: The target changes its SDA drive only while SCL is low, and it sends data MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 requests the pad to pull SDA low |
| live_i | input | 16 | Live read-back values for indexes 12 (bits 7:0) and 13 (bits 15:8) |
| ctrl_o | output | 64 | Stored control registers, indexes 4 to 11 |

## Verification
On every cycle the assertions check four things. The SDA drive only starts or stops while the line monitor sees SCL low. A STOP always leaves SDA released. The control bus only moves on the cycle after a write strobe. Every write strobe comes with an acknowledge drive. Only the directed frames can show the decoding behaviour: the address match, the command-zero base and the count prefix, the plus-one numbering in byte mode, the refusal of surplus bytes, the reserved, constant and live indexes, and recovery after an aborted frame.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_COUNT,
        PH_DATA,
        PH_DONE
    } wr_phase_e;

    typedef struct packed {
        tgt_state_e state;
        wr_phase_e  phase;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic [7:0] remain;
        logic       blk;
        logic       rw;
        logic       mack;
        logic       oe;
        logic       we;
        logic [7:0] we_idx;
        logic [7:0] we_data;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_s;
            sda_p_q  <= sda_s;
        end
    end

    assign scl_s      = scl_sh_q[STAGES-1];
    assign sda_s      = sda_sh_q[STAGES-1];
    assign sda_lvl_o  = sda_s;
    assign scl_rise_o = scl_s & ~scl_p_q;
    assign scl_fall_o = ~scl_s & scl_p_q;
    assign start_o    = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_o     = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int         BASE_IDX  = 4,
    parameter int         LIVE_IDX  = 12,
    parameter int         LIVE_NUM  = 2,
    parameter int         ID_IDX    = 14,
    parameter int         VER_IDX   = 15,
    parameter logic [7:0] ID_VAL    = 8'h77,
    parameter logic [7:0] VER_VAL   = 8'h11,
    parameter logic [8*(LIVE_IDX-BASE_IDX)-1:0] CTRL_RST = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [7:0]                         wr_idx_i,
    input  logic [7:0]                         wr_data_i,
    input  logic [7:0]                         rd_idx_i,
    output logic [7:0]                         rd_data_o,
    input  logic [8*LIVE_NUM-1:0]              live_i,
    output logic [8*(LIVE_IDX-BASE_IDX)-1:0]   ctrl_o
);

    localparam int STORE_NUM = LIVE_IDX - BASE_IDX;
    localparam int SW        = (STORE_NUM > 1) ? $clog2(STORE_NUM) : 1;
    localparam int LW        = (LIVE_NUM > 1) ? $clog2(LIVE_NUM) : 1;

    logic [7:0] store_q [STORE_NUM];

    for (genvar g = 0; g < STORE_NUM; g++) begin : g_store
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q[g] <= CTRL_RST[8*g +: 8];
            end else if (wr_en_i && (wr_idx_i == 8'(BASE_IDX + g))) begin
                store_q[g] <= wr_data_i;
            end
        end
        assign ctrl_o[8*g +: 8] = store_q[g];
    end

    logic [7:0] store_off, live_off;
    assign store_off = rd_idx_i - 8'(BASE_IDX);
    assign live_off  = rd_idx_i - 8'(LIVE_IDX);

    always_comb begin
        rd_data_o = 8'h00;
        if ((rd_idx_i >= 8'(BASE_IDX)) && (rd_idx_i < 8'(LIVE_IDX))) begin
            rd_data_o = store_q[store_off[SW-1:0]];
        end else if ((rd_idx_i >= 8'(LIVE_IDX)) && (rd_idx_i < 8'(LIVE_IDX + LIVE_NUM))) begin
            rd_data_o = live_i[8*live_off[LW-1:0] +: 8];
        end else if (rd_idx_i == 8'(ID_IDX)) begin
            rd_data_o = ID_VAL;
        end else if (rd_idx_i == 8'(VER_IDX)) begin
            rd_data_o = VER_VAL;
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_regs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h69,
    parameter int         BASE_IDX  = 4,
    parameter logic [7:0] BLK_COUNT = 8'd12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    output logic [7:0] rd_idx_o,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_idx_o,
    output logic [7:0] wr_data_o
);

    tgt_regs_t q, d;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_i) begin
            d.state = ST_ADDR;
            d.cnt   = 4'd0;
            d.oe    = 1'b0;
        end else if (stop_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_lvl_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && (q.cnt == 4'd8)) begin
                        if (q.sh[7:1] == DEV_ADDR7) begin
                            d.oe    = 1'b1;
                            d.rw    = q.sh[0];
                            d.state = ST_ADDR_ACK;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = 4'd0;
                        if (q.rw) begin
                            if (q.blk) begin
                                d.tx  = BLK_COUNT;
                                d.ptr = 8'(BASE_IDX);
                            end else begin
                                d.tx  = rd_data_i;
                                d.ptr = q.ptr + 8'd1;
                            end
                            d.oe    = ~d.tx[7];
                            d.state = ST_RD;
                        end else begin
                            d.oe    = 1'b0;
                            d.phase = PH_CMD;
                            d.state = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_lvl_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && (q.cnt == 4'd8)) begin
                        d.state = ST_WR_ACK;
                        d.oe    = 1'b1;
                        case (q.phase)
                            PH_CMD: begin
                                if (q.sh == 8'h00) begin
                                    d.blk   = 1'b1;
                                    d.ptr   = 8'(BASE_IDX);
                                    d.phase = PH_COUNT;
                                end else begin
                                    d.blk   = 1'b0;
                                    d.ptr   = q.sh - 8'd1;
                                    d.phase = PH_DATA;
                                end
                            end
                            PH_COUNT: begin
                                d.remain = q.sh;
                                d.phase  = (q.sh == 8'h00) ? PH_DONE : PH_DATA;
                            end
                            PH_DATA: begin
                                d.we      = 1'b1;
                                d.we_idx  = q.ptr;
                                d.we_data = q.sh;
                                d.ptr     = q.ptr + 8'd1;
                                if (!q.blk || (q.remain == 8'd1)) begin
                                    d.phase = PH_DONE;
                                end else begin
                                    d.remain = q.remain - 8'd1;
                                end
                            end
                            default: begin
                                d.oe = 1'b0;
                            end
                        endcase
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.oe    = 1'b0;
                        d.cnt   = 4'd0;
                        d.state = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd7) begin
                            d.oe    = 1'b0;
                            d.state = ST_RD_ACK;
                        end else begin
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.oe  = ~d.tx[7];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.tx    = rd_data_i;
                            d.ptr   = q.ptr + 8'd1;
                            d.oe    = ~d.tx[7];
                            d.cnt   = 4'd0;
                            d.state = ST_RD;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.phase   <= PH_CMD;
            q.cnt     <= 4'd0;
            q.sh      <= 8'h00;
            q.tx      <= 8'h00;
            q.ptr     <= 8'(BASE_IDX);
            q.remain  <= 8'h00;
            q.blk     <= 1'b1;
            q.rw      <= 1'b0;
            q.mack    <= 1'b0;
            q.oe      <= 1'b0;
            q.we      <= 1'b0;
            q.we_idx  <= 8'h00;
            q.we_data <= 8'h00;
        end else begin
            q <= d;
        end
    end

    assign rd_idx_o  = q.ptr;
    assign sda_oe_o  = q.oe;
    assign wr_en_o   = q.we;
    assign wr_idx_o  = q.we_idx;
    assign wr_data_o = q.we_data;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [6:0] DEV_ADDR7   = 7'h69,
    parameter int         REG_COUNT   = 16,
    parameter int         BASE_IDX    = 4,
    parameter int         LIVE_IDX    = 12,
    parameter int         LIVE_NUM    = 2,
    parameter int         ID_IDX      = 14,
    parameter int         VER_IDX     = 15,
    parameter logic [7:0] ID_VAL      = 8'h77,
    parameter logic [7:0] VER_VAL     = 8'h11,
    parameter int         SYNC_STAGES = 2,
    parameter logic [8*(LIVE_IDX-BASE_IDX)-1:0] CTRL_RST = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             scl_i,
    input  logic                             sda_i,
    output logic                             sda_oe_o,
    input  logic [8*LIVE_NUM-1:0]            live_i,
    output logic [8*(LIVE_IDX-BASE_IDX)-1:0] ctrl_o
);

    localparam int         CTRL_W    = 8 * (LIVE_IDX - BASE_IDX);
    localparam logic [7:0] BLK_COUNT = 8'(REG_COUNT - BASE_IDX);

    logic       sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
    logic       wr_en;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_target_fsm #(
        .DEV_ADDR7 (DEV_ADDR7),
        .BASE_IDX  (BASE_IDX),
        .BLK_COUNT (BLK_COUNT)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .rd_idx_o   (rd_idx),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    i2c_reg_bank #(
        .BASE_IDX (BASE_IDX),
        .LIVE_IDX (LIVE_IDX),
        .LIVE_NUM (LIVE_NUM),
        .ID_IDX   (ID_IDX),
        .VER_IDX  (VER_IDX),
        .ID_VAL   (ID_VAL),
        .VER_VAL  (VER_VAL),
        .CTRL_RST (CTRL_RST)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .live_i    (live_i),
        .ctrl_o    (ctrl_o)
    );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
    parameter int CTRL_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              stop_evt,
    input logic              wr_en,
    input logic              sda_oe_o,
    input logic [CTRL_W-1:0] ctrl_o
);

    logic scl_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_hi_q <= 1'b1;
        end else if (scl_rise) begin
            scl_hi_q <= 1'b1;
        end else if (scl_fall) begin
            scl_hi_q <= 1'b0;
        end
    end

    a_r11_drive_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_hi_q);

    a_r11_drive_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_hi_q);

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_o);

    a_r10_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(ctrl_o));

    a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe_o);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.CTRL_W(CTRL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .stop_evt (stop_evt),
    .wr_en    (wr_en),
    .sda_oe_o (sda_oe_o),
    .ctrl_o   (ctrl_o)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [15:0] live = 16'h0000;
    logic        sda_oe;
    logic [63:0] ctrl;
    logic [63:0] exp_ctrl = 64'h0;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2c_reg_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .live_i   (live),
        .ctrl_o   (ctrl)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP);
        sda_m = 1'b0; wait_clk(HP);
        scl_m = 1'b0; wait_clk(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP);
        sda_m = 1'b1; wait_clk(HP);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP/2);
        b = sda_bus;  wait_clk(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic t_reset();
        chk(ctrl == 64'h0, "R10 reset ctrl", ctrl, 64'h0);
        chk(sda_oe == 1'b0, "R2 reset sda released", 64'(sda_oe), 64'h0);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        put_byte(8'hD0, a);
        chk(a == 1'b0, "R1 nack 0xD0", 64'(a), 64'h0);
        put_byte(8'h00, a);
        chk(a == 1'b0, "R1 silent after nack", 64'(a), 64'h0);
        bus_stop();
        bus_start();
        put_byte(8'hA4, a);
        chk(a == 1'b0, "R1 nack 0xA4", 64'(a), 64'h0);
        bus_stop();
        wait_clk(4);
        chk(ctrl == exp_ctrl, "R1 no write on bad address", ctrl, exp_ctrl);
    endtask

    task automatic t_block_write();
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        chk(a == 1'b1, "R1 ack 0xD2", 64'(a), 64'h1);
        put_byte(8'h00, a);
        put_byte(8'h03, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        put_byte(8'h33, a);
        chk(a == 1'b1, "R3 last counted byte ack", 64'(a), 64'h1);
        put_byte(8'h44, a);
        chk(a == 1'b0, "R3 surplus byte nack", 64'(a), 64'h0);
        bus_stop();
        wait_clk(4);
        exp_ctrl[23:0] = 24'h332211;
        chk(ctrl == exp_ctrl, "R3 block write to index 4..6", ctrl, exp_ctrl);
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        put_byte(8'h99, a);
        chk(a == 1'b0, "R3 zero count refuses data", 64'(a), 64'h0);
        bus_stop();
        wait_clk(4);
        chk(ctrl == exp_ctrl, "R3 zero count writes nothing", ctrl, exp_ctrl);
    endtask

    task automatic t_byte_write();
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h0A, a);
        put_byte(8'h5A, a);
        chk(a == 1'b1, "R5 data ack", 64'(a), 64'h1);
        put_byte(8'h66, a);
        chk(a == 1'b0, "R5 second byte nack", 64'(a), 64'h0);
        bus_stop();
        wait_clk(4);
        exp_ctrl[47:40] = 8'h5A;
        chk(ctrl == exp_ctrl, "R5 byte write index 9", ctrl, exp_ctrl);
    endtask

    task automatic byte_read2(input logic [7:0] cmd, output logic [7:0] v0, output logic [7:0] v1);
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        put_byte(cmd, a);
        bus_start();
        put_byte(8'hD3, a);
        chk(a == 1'b1, "R1 ack 0xD3", 64'(a), 64'h1);
        get_byte(v0, 1'b1);
        get_byte(v1, 1'b0);
        bus_stop();
        wait_clk(4);
    endtask

    task automatic byte_write1(input logic [7:0] cmd, input logic [7:0] v);
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        put_byte(cmd, a);
        put_byte(v, a);
        bus_stop();
        wait_clk(4);
    endtask

    task automatic t_reserved();
        logic [7:0] v0, v1;
        byte_write1(8'h02, 8'hFF);
        chk(ctrl == exp_ctrl, "R7 reserved write ignored", ctrl, exp_ctrl);
        byte_read2(8'h02, v0, v1);
        chk(v0 == 8'h00, "R7 reserved index 1 reads zero", 64'(v0), 64'h0);
        chk(v1 == 8'h00, "R7 reserved index 2 reads zero", 64'(v1), 64'h0);
    endtask

    task automatic t_ident();
        logic [7:0] v0, v1;
        byte_write1(8'h0F, 8'h00);
        byte_read2(8'h0F, v0, v1);
        chk(v0 == 8'h77, "R8 index 14 id", 64'(v0), 64'h77);
        chk(v1 == 8'h11, "R8 index 15 version (R6 increment)", 64'(v1), 64'h11);
    endtask

    task automatic t_live();
        logic [7:0] v0, v1;
        live = 16'hC35A;
        byte_write1(8'h0D, 8'h00);
        chk(ctrl == exp_ctrl, "R9 live write ignored", ctrl, exp_ctrl);
        byte_read2(8'h0D, v0, v1);
        chk(v0 == 8'h5A, "R9 live index 12", 64'(v0), 64'h5A);
        chk(v1 == 8'hC3, "R9 live index 13", 64'(v1), 64'hC3);
        live = 16'h0F81;
        byte_read2(8'h0D, v0, v1);
        chk(v0 == 8'h81, "R9 live follows input", 64'(v0), 64'h81);
    endtask

    task automatic t_byte_read();
        logic [7:0] v0, v1;
        byte_read2(8'h0A, v0, v1);
        chk(v0 == 8'h5A, "R6 byte read index 9 (R11 msb first)", 64'(v0), 64'h5A);
        chk(v1 == 8'h00, "R6 next index 10", 64'(v1), 64'h00);
    endtask

    task automatic t_block_read();
        logic       a;
        logic [7:0] v;
        logic [7:0] exp_v [5];
        exp_v = '{8'h0C, 8'h11, 8'h22, 8'h33, 8'h00};
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        bus_start();
        put_byte(8'hD3, a);
        for (int i = 0; i < 5; i++) begin
            get_byte(v, (i < 4));
            chk(v == exp_v[i], "R4 block read byte", 64'(v), 64'(exp_v[i]));
        end
        wait_clk(2);
        chk(sda_oe == 1'b0, "R4 released after host nack", 64'(sda_oe), 64'h0);
        bus_stop();
    endtask

    task automatic t_abort();
        logic       a;
        logic [7:0] v;
        bus_start();
        put_byte(8'hD2, a);
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        bus_stop();
        wait_clk(4);
        chk(sda_oe == 1'b0, "R2 stop mid byte releases", 64'(sda_oe), 64'h0);
        chk(ctrl == exp_ctrl, "R2 aborted frame writes nothing", ctrl, exp_ctrl);
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        bus_start();
        put_byte(8'hD3, a);
        chk(a == 1'b1, "R2 repeated start address ack", 64'(a), 64'h1);
        get_byte(v, 1'b0);
        chk(v == 8'h0C, "R2 frame after abort", 64'(v), 64'h0C);
        bus_stop();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_bad_addr();
        t_block_write();
        t_byte_write();
        t_reserved();
        t_ident();
        t_live();
        t_byte_read();
        t_block_read();
        t_abort();
        wait_clk(10);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule